// File: doc/BRIEF.md
# CEC Receive Message Store

This block sits behind a CEC bit receiver. It keeps up to three completed frames until host software collects them. The receiver drives a short frame-write protocol: a start pulse, one strobe per received byte, and an end pulse. The block collects the bytes in a staging register. When the end pulse arrives, it moves the frame into a free slot. Each slot holds a length, a header byte and up to fifteen data bytes.

Every occupied slot carries a two-bit arrival stamp, so software can drain messages oldest first. When a slot is released, the stamps of younger messages move down by one. The stamps therefore always run without gaps from 1.

A mode input limits storage to the first slot only. Frames that find no free slot are dropped, and a sticky overflow flag records the loss. Each slot raises its own interrupt status when it is filled. An enable mask selects which status bits drive the combined interrupt line.

Top module: `cec_rx_msgstore`

## Requirements
- R1: After reset all slots are empty, every stamp is 0, the overflow flag is 0, all interrupt status bits are 0, and a frame is accepted with no enabling write.
- R2: The first byte after the start pulse is read back at index 0 (the header). Later bytes are read at indices 1 to 15. The stored length equals the number of bytes received, including the header. Bytes after the sixteenth are ignored. Indices at or beyond the length read as 0. A frame with no bytes is discarded without touching any state.
- R3: A completed frame goes into the lowest-numbered free slot that the mode allows. Bit 0 of every per-slot vector is buffer 1, bit 1 is buffer 2 and bit 2 is buffer 3.
- R4: Stamp value 0 marks an empty slot, and values 1, 2 and 3 mark the oldest, second-oldest and third-oldest held message. A new message gets a stamp equal to the number of messages held after it is stored. `stamps[2s+1:2s]` is the stamp of slot s.
- R5: A pulse on `clr_rdy[s]` while slot s is ready empties it on the next cycle: ready 0, stamp 0, length 0. Every other held slot with a larger stamp drops by one for each released slot older than it. Several slots may be released together. A pulse on an empty slot has no effect.
- R6: With `mode_all` = 0 only buffer 1 accepts frames, and the other slots keep whatever they hold. With `mode_all` = 1 all three slots accept frames.
- R7: A non-empty frame that finds no allowed free slot is dropped. It sets `ovf`, which stays at 1 until reset.
- R8: Storing into slot s sets `irq_stat[s]`. Writing 1 to `irq_clr[s]` clears it, except when a store to the same slot happens in the same cycle, in which case the store wins. `irq` is the OR of `irq_stat & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_start | input | 1 | Start of a received frame; clears the staging count |
| fr_byte_vld | input | 1 | A received byte is on `fr_byte` |
| fr_byte | input | 8 | Received byte value |
| fr_end | input | 1 | End of frame; commits the staged bytes |
| mode_all | input | 1 | 1 = three slots, 0 = buffer 1 only |
| clr_rdy | input | 3 | Per-slot release strobes |
| irq_en | input | 3 | Per-slot interrupt enables |
| irq_clr | input | 3 | Per-slot write-one-to-clear of interrupt status |
| rd_slot | input | 2 | Slot selected for reading |
| rd_idx | input | 4 | Byte index in the selected slot (0 = header) |
| rd_len | output | 5 | Length of the selected slot |
| rd_byte | output | 8 | Byte at `rd_idx` of the selected slot |
| rdy | output | 3 | Per-slot message-held flags |
| stamps | output | 6 | Per-slot arrival stamps, two bits each |
| ovf | output | 1 | Sticky dropped-frame flag |
| irq_stat | output | 3 | Per-slot interrupt status |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench releases a full set of slots in all six orders, one slot at a time. A design that forgets to renumber would leave a gap, such as stamps 2 and 3 with no 1, or would decrement messages older than the released one. A paired release of buffers 1 and 3 checks that a message younger than both drops by two, not one.

A sweep of frame lengths from 0 to 18 bytes checks the empty-frame discard and the saturation at sixteen bytes. It also checks that stale bytes from a longer earlier frame are zeroed. A design that committed empty frames or wrapped its byte counter would show a wrong length or corrupted data.

Refilling after a middle release checks that a new frame takes the lowest free slot with the newest stamp, and does not simply take the next slot in turn. The single-slot mode and the interrupt sweep cover overflow stickiness and every enable/clear mask pair.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
    parameter int unsigned NSLOT       = 3;
    parameter int unsigned FRAME_BYTES = 16;
    parameter int unsigned BYTE_W      = 8;

    localparam int unsigned LEN_W   = $clog2(FRAME_BYTES + 1);
    localparam int unsigned IDX_W   = $clog2(FRAME_BYTES);
    localparam int unsigned STAMP_W = $clog2(NSLOT + 1);
    localparam int unsigned SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    typedef logic [BYTE_W-1:0]                   byte_t;
    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0]  frame_t;
    typedef logic [LEN_W-1:0]                    len_t;
    typedef logic [STAMP_W-1:0]                  stamp_t;

    typedef struct packed {
        len_t   len;
        frame_t data;
    } slot_t;
endpackage

// File: rtl/cec_rx_stage.sv
module cec_rx_stage
    import cec_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   byte_vld_i,
    input  byte_t  byte_i,
    input  logic   end_i,
    output logic   commit_o,
    output len_t   len_o,
    output frame_t data_o
);
    typedef struct packed {
        len_t   cnt;
        frame_t data;
    } stage_t;

    stage_t stage_q, stage_d, eff;

    always_comb begin
        eff = stage_q;
        if (start_i) begin
            eff.cnt = '0;
        end
        // bytes past the last position are dropped; count saturates
        if (byte_vld_i && (eff.cnt < len_t'(FRAME_BYTES))) begin
            eff.data[eff.cnt[IDX_W-1:0]] = byte_i;
            eff.cnt = eff.cnt + len_t'(1);
        end
        commit_o = end_i && (eff.cnt != '0);
        len_o    = eff.cnt;
        data_o   = eff.data;
        stage_d  = eff;
        if (end_i) begin
            stage_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/cec_rx_order.sv
module cec_rx_order
    import cec_rx_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit_i,
    input  logic                            mode_all_i,
    input  logic [NSLOT-1:0]                clr_i,
    output logic [NSLOT-1:0]                rdy_o,
    output logic [NSLOT-1:0]                rel_o,
    output logic [NSLOT-1:0]                wr_o,
    output logic [NSLOT-1:0][STAMP_W-1:0]   stamp_o,
    output logic                            ovf_o
);
    typedef struct packed {
        logic [NSLOT-1:0][STAMP_W-1:0] stamp;
        logic                          ovf;
    } ord_t;

    ord_t ord_q, ord_d;

    logic [NSLOT-1:0] held;
    logic [NSLOT-1:0] allow;
    logic [NSLOT-1:0] rel;
    logic [NSLOT-1:0] keep;
    logic [NSLOT-1:0] free;
    stamp_t           n_keep;
    logic             found;

    for (genvar s = 0; s < NSLOT; s++) begin : g_flags
        assign held[s] = (ord_q.stamp[s] != '0);
        if (s == 0) begin : g_first
            assign allow[s] = 1'b1;
        end else begin : g_rest
            assign allow[s] = mode_all_i;
        end
    end

    always_comb begin
        stamp_t dec;
        rel    = clr_i & held;
        keep   = held & ~rel;
        free   = ~held & allow;
        n_keep = '0;
        for (int i = 0; i < NSLOT; i++) begin
            n_keep = n_keep + stamp_t'(keep[i]);
        end

        ord_d = ord_q;
        wr_o  = '0;
        found = 1'b0;

        // renumber: each surviving stamp drops by the count of released older ones
        for (int i = 0; i < NSLOT; i++) begin
            dec = '0;
            for (int j = 0; j < NSLOT; j++) begin
                if (rel[j] && (ord_q.stamp[j] < ord_q.stamp[i])) begin
                    dec = dec + stamp_t'(1);
                end
            end
            ord_d.stamp[i] = keep[i] ? (ord_q.stamp[i] - dec) : '0;
        end

        if (commit_i) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (!found && free[i]) begin
                    found          = 1'b1;
                    wr_o[i]        = 1'b1;
                    ord_d.stamp[i] = n_keep + stamp_t'(1);
                end
            end
            if (!found) begin
                ord_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_q <= '0;
        end else begin
            ord_q <= ord_d;
        end
    end

    assign rdy_o   = held;
    assign rel_o   = rel;
    assign stamp_o = ord_q.stamp;
    assign ovf_o   = ord_q.ovf;
endmodule

// File: rtl/cec_rx_slots.sv
module cec_rx_slots
    import cec_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  wr_i,
    input  logic [NSLOT-1:0]  rel_i,
    input  len_t              len_i,
    input  frame_t            data_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output len_t              rd_len_o,
    output byte_t             rd_byte_o
);
    frame_t masked;
    slot_t  slot_rd [NSLOT];

    // positions past the frame length are stored as zero
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_mask
        assign masked[k] = (len_t'(k) < len_i) ? data_i[k] : '0;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_t slot_q, slot_d;

        always_comb begin
            slot_d = slot_q;
            if (rel_i[s]) begin
                slot_d = '0;
            end
            if (wr_i[s]) begin
                slot_d.len  = len_i;
                slot_d.data = masked;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_rd[s] = slot_q;
    end

    always_comb begin
        rd_len_o  = '0;
        rd_byte_o = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_slot_i == SLOT_W'(s)) begin
                rd_len_o  = slot_rd[s].len;
                rd_byte_o = slot_rd[s].data[rd_idx_i];
            end
        end
    end
endmodule

// File: rtl/cec_rx_msgstore.sv
module cec_rx_msgstore
    import cec_rx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fr_start,
    input  logic                       fr_byte_vld,
    input  logic [BYTE_W-1:0]          fr_byte,
    input  logic                       fr_end,
    input  logic                       mode_all,
    input  logic [NSLOT-1:0]           clr_rdy,
    input  logic [NSLOT-1:0]           irq_en,
    input  logic [NSLOT-1:0]           irq_clr,
    input  logic [SLOT_W-1:0]          rd_slot,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [LEN_W-1:0]           rd_len,
    output logic [BYTE_W-1:0]          rd_byte,
    output logic [NSLOT-1:0]           rdy,
    output logic [NSLOT*STAMP_W-1:0]   stamps,
    output logic                       ovf,
    output logic [NSLOT-1:0]           irq_stat,
    output logic                       irq
);
    logic                          commit;
    len_t                          stg_len;
    frame_t                        stg_data;
    logic [NSLOT-1:0]              rel;
    logic [NSLOT-1:0]              wr;
    logic [NSLOT-1:0][STAMP_W-1:0] stamp_arr;

    cec_rx_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (fr_start),
        .byte_vld_i (fr_byte_vld),
        .byte_i     (fr_byte),
        .end_i      (fr_end),
        .commit_o   (commit),
        .len_o      (stg_len),
        .data_o     (stg_data)
    );

    cec_rx_order u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .mode_all_i (mode_all),
        .clr_i      (clr_rdy),
        .rdy_o      (rdy),
        .rel_o      (rel),
        .wr_o       (wr),
        .stamp_o    (stamp_arr),
        .ovf_o      (ovf)
    );

    cec_rx_slots u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .rel_i     (rel),
        .len_i     (stg_len),
        .data_i    (stg_data),
        .rd_slot_i (rd_slot),
        .rd_idx_i  (rd_idx),
        .rd_len_o  (rd_len),
        .rd_byte_o (rd_byte)
    );

    assign stamps = stamp_arr;

    typedef struct packed {
        logic [NSLOT-1:0] stat;
    } irq_t;

    irq_t irq_q, irq_d;

    always_comb begin
        irq_d      = irq_q;
        // a store in the same cycle wins over the clear
        irq_d.stat = (irq_q.stat & ~irq_clr) | wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_stat = irq_q.stat;
    assign irq      = |(irq_q.stat & irq_en);
endmodule

// File: rtl/cec_rx_msgstore_chk.sv
module cec_rx_msgstore_chk
    import cec_rx_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fr_end,
    input logic                     mode_all,
    input logic [NSLOT-1:0]         clr_rdy,
    input logic [NSLOT-1:0]         irq_clr,
    input logic [NSLOT-1:0]         rdy,
    input logic [NSLOT*STAMP_W-1:0] stamps,
    input logic                     ovf,
    input logic [NSLOT-1:0]         irq_stat
);
    int held_cnt;
    int max_st;
    int sum_st;

    always_comb begin
        held_cnt = $countones(rdy);
        max_st   = 0;
        sum_st   = 0;
        for (int i = 0; i < NSLOT; i++) begin
            if (int'(stamps[i*STAMP_W +: STAMP_W]) > max_st) begin
                max_st = int'(stamps[i*STAMP_W +: STAMP_W]);
            end
            sum_st = sum_st + int'(stamps[i*STAMP_W +: STAMP_W]);
        end
    end

    // R4: held stamps are exactly 1..count
    p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (max_st == held_cnt) && (sum_st == (held_cnt * (held_cnt + 1)) / 2));

    // R7: overflow is sticky
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [STAMP_W-1:0] st;
        assign st = stamps[s*STAMP_W +: STAMP_W];

        p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_rdy[s] && rdy[s]) |=> !rdy[s]);

        p_stamp_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy[s]) |-> (st == STAMP_W'($countones(rdy))));

        p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy[s]) |-> irq_stat[s]);

        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_clr[s] && !fr_end) |=> !irq_stat[s]);

        if (s > 0) begin : g_upper
            p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode_all && !rdy[s]) |=> !rdy[s]);
        end
    end
endmodule

bind cec_rx_msgstore cec_rx_msgstore_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_end   (fr_end),
    .mode_all (mode_all),
    .clr_rdy  (clr_rdy),
    .irq_clr  (irq_clr),
    .rdy      (rdy),
    .stamps   (stamps),
    .ovf      (ovf),
    .irq_stat (irq_stat)
);

// File: tb/sim_cec_rx_msgstore.sv
`timescale 1ns/1ps
module sim_cec_rx_msgstore;
    import cec_rx_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     fr_start = 1'b0;
    logic                     fr_byte_vld = 1'b0;
    logic [BYTE_W-1:0]        fr_byte = '0;
    logic                     fr_end = 1'b0;
    logic                     mode_all = 1'b1;
    logic [NSLOT-1:0]         clr_rdy = '0;
    logic [NSLOT-1:0]         irq_en = '0;
    logic [NSLOT-1:0]         irq_clr = '0;
    logic [SLOT_W-1:0]        rd_slot = '0;
    logic [IDX_W-1:0]         rd_idx = '0;
    logic [LEN_W-1:0]         rd_len;
    logic [BYTE_W-1:0]        rd_byte;
    logic [NSLOT-1:0]         rdy;
    logic [NSLOT*STAMP_W-1:0] stamps;
    logic                     ovf;
    logic [NSLOT-1:0]         irq_stat;
    logic                     irq;

    always #4 clk = ~clk;

    cec_rx_msgstore u0 (
        .clk(clk), .rst_n(rst_n), .fr_start(fr_start), .fr_byte_vld(fr_byte_vld),
        .fr_byte(fr_byte), .fr_end(fr_end), .mode_all(mode_all), .clr_rdy(clr_rdy),
        .irq_en(irq_en), .irq_clr(irq_clr), .rd_slot(rd_slot), .rd_idx(rd_idx),
        .rd_len(rd_len), .rd_byte(rd_byte), .rdy(rdy), .stamps(stamps), .ovf(ovf),
        .irq_stat(irq_stat), .irq(irq)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    bit    m_rdy   [NSLOT];
    int    m_stamp [NSLOT];
    int    m_len   [NSLOT];
    byte_t m_data  [NSLOT][FRAME_BYTES];
    bit    m_irq   [NSLOT];
    bit    m_ovf;

    int perms [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic byte_t bval(int seed, int k);
        return byte_t'(seed * 37 + k * 11 + 5);
    endfunction

    task automatic model_clear();
        for (int s = 0; s < NSLOT; s++) begin
            m_rdy[s] = 0; m_stamp[s] = 0; m_len[s] = 0; m_irq[s] = 0;
            for (int k = 0; k < FRAME_BYTES; k++) m_data[s][k] = '0;
        end
        m_ovf = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fr_start = 0; fr_byte_vld = 0; fr_end = 0; clr_rdy = '0; irq_clr = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(int n, int seed);
        int held;
        int t;
        @(negedge clk) fr_start = 1'b1;
        @(negedge clk) fr_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            fr_byte_vld = 1'b1;
            fr_byte     = bval(seed, k);
            @(negedge clk);
        end
        fr_byte_vld = 1'b0;
        fr_end = 1'b1;
        @(negedge clk);
        fr_end = 1'b0;
        if (n > 0) begin
            held = 0; t = -1;
            for (int s = 0; s < NSLOT; s++) held += m_rdy[s];
            for (int s = 0; s < NSLOT; s++)
                if (t < 0 && !m_rdy[s] && (mode_all || s == 0)) t = s;
            if (t < 0) m_ovf = 1;
            else begin
                m_rdy[t] = 1; m_stamp[t] = held + 1; m_irq[t] = 1;
                m_len[t] = (n > FRAME_BYTES) ? FRAME_BYTES : n;
                for (int k = 0; k < FRAME_BYTES; k++)
                    m_data[t][k] = (k < m_len[t]) ? bval(seed, k) : '0;
            end
        end
    endtask

    task automatic release_slots(bit [NSLOT-1:0] mask);
        int nst [NSLOT];
        @(negedge clk) clr_rdy = mask;
        @(negedge clk) clr_rdy = '0;
        for (int i = 0; i < NSLOT; i++) begin
            nst[i] = m_stamp[i];
            if (m_rdy[i] && !mask[i])
                for (int j = 0; j < NSLOT; j++)
                    if (mask[j] && m_rdy[j] && m_stamp[j] < m_stamp[i]) nst[i]--;
        end
        for (int i = 0; i < NSLOT; i++) begin
            m_stamp[i] = nst[i];
            if (mask[i] && m_rdy[i]) begin
                m_rdy[i] = 0; m_stamp[i] = 0; m_len[i] = 0;
                for (int k = 0; k < FRAME_BYTES; k++) m_data[i][k] = '0;
            end
        end
    endtask

    task automatic w1c(bit [NSLOT-1:0] mask);
        @(negedge clk) irq_clr = mask;
        @(negedge clk) irq_clr = '0;
        for (int s = 0; s < NSLOT; s++) if (mask[s]) m_irq[s] = 0;
    endtask

    task automatic check_all(string req);
        bit any_irq = 0;
        for (int s = 0; s < NSLOT; s++) begin
            chk(req, $sformatf("rdy[%0d]", s), int'(rdy[s]), int'(m_rdy[s]));
            chk(req, $sformatf("stamp[%0d]", s), int'(stamps[s*STAMP_W +: STAMP_W]), m_stamp[s]);
            chk(req, $sformatf("irq_stat[%0d]", s), int'(irq_stat[s]), int'(m_irq[s]));
            if (m_irq[s] && irq_en[s]) any_irq = 1;
            rd_slot = SLOT_W'(s);
            for (int k = 0; k < FRAME_BYTES; k++) begin
                rd_idx = IDX_W'(k);
                #0.2;
                if (k == 0) chk(req, $sformatf("len[%0d]", s), int'(rd_len), m_len[s]);
                chk(req, $sformatf("byte[%0d][%0d]", s, k), int'(rd_byte), int'(m_data[s][k]));
            end
        end
        chk(req, "ovf", int'(ovf), int'(m_ovf));
        chk(req, "irq", int'(irq), int'(any_irq));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        irq_en = '1;
        do_reset();
        check_all("R1");
        send(3, 1);                       // R1: accepted with no enabling write
        check_all("R1");
        release_slots(3'b111);
        check_all("R5");

        // R2: length sweep including empty and oversize frames
        for (int n = 0; n <= FRAME_BYTES + 2; n++) begin
            send(n, n + 10);
            check_all("R2");
            release_slots(3'b001);
            check_all("R2");
        end

        // R4/R5: every release order of a full store
        for (int p = 0; p < 6; p++) begin
            send(2, 20 + p); send(9, 30 + p); send(16, 40 + p);
            check_all("R4");
            for (int s = 0; s < NSLOT; s++) begin
                release_slots(NSLOT'(1) << perms[p][s]);
                check_all("R5");
            end
        end

        // R3: refill after a middle release takes that slot with the newest stamp
        send(4, 50); send(5, 51); send(6, 52);
        release_slots(3'b010);
        send(5, 77);
        check_all("R3");
        release_slots(3'b101);            // R5: paired release
        check_all("R5");
        release_slots(3'b101);            // R5: release of empty slots
        check_all("R5");
        release_slots(3'b111);
        send(2, 60); send(3, 61);
        release_slots(3'b001);
        send(7, 62);                      // R3: lowest free is buffer 1
        check_all("R3");
        release_slots(3'b111);

        // R8: every enable against every clear mask
        for (int en = 0; en < 8; en++) begin
            for (int msk = 0; msk < 8; msk++) begin
                irq_en = NSLOT'(en);
                send(1, en); send(2, msk); send(3, en + msk);
                w1c(NSLOT'(msk));
                check_all("R8");
                release_slots(3'b111);
            end
        end
        irq_en = '1;

        // R7: overflow and its stickiness
        send(3, 70); send(3, 71); send(3, 72);
        send(4, 73);
        check_all("R7");
        release_slots(3'b111);
        check_all("R7");
        send(2, 74);
        check_all("R7");

        // R6: single-slot mode
        do_reset();
        mode_all = 1'b0;
        send(2, 80);
        send(3, 81);
        check_all("R6");
        release_slots(3'b001);
        send(6, 82);
        check_all("R6");
        mode_all = 1'b1;
        send(4, 83);
        check_all("R6");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule